// File: doc/BRIEF.md
# Dual-Array Access Arbiter and Write Guard

This block sits in front of a device that keeps two memory arrays on one shared bus: a large program array and a smaller data array. Each array has its own active-low chip enable, and both share the active-low write and output enables. Every system clock the block looks at the bus strobes, the supply-good indication and the busy flags from the two write controllers. It then raises at most one qualified strobe: a read, a write or a polling read for one array.

Writes are protected in three ways. A glitch filter requires the write enable to be held low for a set number of clock samples. A power-up lockout keeps writes blocked for a set number of cycles after the supply becomes good. The usual inhibit conditions also block writes. Reads follow concurrency rules. The program array stays readable while the data array writes. A data-array read is refused while the program array writes. A read of an array during its own write becomes a polling read. Illegal accesses set a sticky error flag, and only reset clears it.

Top module: `dual_array_guard`

## Requirements
- R1: A write strobe is raised only once `we_n` has been sampled low on at least `FILT_CYCLES` consecutive rising clock edges and is still low. A shorter low pulse raises no write strobe.
- R2: After `supply_ok` rises, no write strobe appears until `supply_ok` has been sampled high on `LOCK_CYCLES` consecutive edges. Any low sample restarts this count.
- R3: No write strobe is raised while `oe_n` is low, while `we_n` is high, or for an array whose chip enable is high.
- R4: When `ce_prog_n` and `ce_data_n` are both low, no strobe or poll output is raised. If `we_n` or `oe_n` is also low, the access is illegal.
- R5: A read is `oe_n` low with `we_n` high. A program-array read (`ce_prog_n` low, `ce_data_n` high) raises `prog_rd` whenever `prog_busy` is low, whatever the value of `data_busy`.
- R6: A data-array read while `prog_busy` is high raises neither `data_rd` nor `data_poll`, and it is illegal.
- R7: A program-array read while `prog_busy` is high raises `prog_poll` instead of `prog_rd`. A data-array read while only `data_busy` is high raises `data_poll` instead of `data_rd`.
- R8: While `supply_ok` is low, no write strobe is raised, including in the same cycle that it falls.
- R9: `access_err` rises on the clock edge that samples an illegal access. It then stays high until reset.
- R10: Synchronous active-low reset clears `access_err` and both counters, so the lockout and the filter must elapse again.
- R11: A data-array write (`ce_data_n` low, `ce_prog_n` high) raises `data_wr` under the same filter, lockout and inhibit qualifiers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_prog_n | input | 1 | Program-array chip enable, active low |
| ce_data_n | input | 1 | Data-array chip enable, active low |
| we_n | input | 1 | Shared write enable, active low |
| oe_n | input | 1 | Shared output enable, active low |
| supply_ok | input | 1 | Supply above its sense threshold |
| prog_busy | input | 1 | Program-array write cycle in progress |
| data_busy | input | 1 | Data-array write cycle in progress |
| prog_rd | output | 1 | Qualified program-array read |
| prog_wr | output | 1 | Qualified program-array write strobe |
| prog_poll | output | 1 | Program-array read answered as polling |
| data_rd | output | 1 | Qualified data-array read |
| data_wr | output | 1 | Qualified data-array write strobe |
| data_poll | output | 1 | Data-array read answered as polling |
| access_err | output | 1 | Sticky illegal-access flag |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the end of the glitch filter and the end of the power-up lockout: the bench holds the write enable low across the moment the lockout expires, and checks that the write strobe appears only once both counts are complete. The second pair is a supply drop and a write strobe that is already qualified: the bench lowers `supply_ok` while a filtered write is in progress and expects the strobe to disappear in that same cycle. A behavioural model in the bench keeps run-length integers and judges every output on every clock.

// File: rtl/dag_pkg.sv
// Package: shared routing result for the dual-array access guard.
// Assumes: one-bit strobes, active high inside the block.
package dag_pkg;
    typedef struct packed {
        logic prog_rd;
        logic prog_wr;
        logic prog_poll;
        logic data_rd;
        logic data_wr;
        logic data_poll;
        logic illegal;
    } route_t;
endpackage

// File: rtl/dag_run_counter.sv
// Module: saturating run-length counter.
// Counts consecutive clock edges on which 'level' is high and saturates at LIMIT.
// A low sample clears the count. 'done' is high once LIMIT samples have been seen.
// Assumes: LIMIT >= 1, synchronous active-low reset.
module dag_run_counter #(
    parameter int unsigned LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic done
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    logic [CW-1:0] run_q;

    // Track the current run of high samples, saturating at TOP.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (!level)
            run_q <= '0;
        else if (run_q != TOP)
            run_q <= run_q + 1'b1;
    end

    // Report a completed run.
    assign done = (run_q == TOP);
endmodule

// File: rtl/dag_router.sv
// Module: combinational access router.
// Decides which array an access goes to, whether a write is allowed and whether a read
// becomes polling, and flags illegal combinations.
// Assumes: all bus inputs are active low; we_ok and armed come from the run counters.
module dag_router
    import dag_pkg::*;
(
    input  logic   ce_prog_n,
    input  logic   ce_data_n,
    input  logic   we_n,
    input  logic   oe_n,
    input  logic   supply_ok,
    input  logic   we_ok,
    input  logic   armed,
    input  logic   prog_busy,
    input  logic   data_busy,
    output route_t route
);
    logic both_sel, prog_only, data_only, rd_req, wr_allow;

    // Qualify the access type and the selected array.
    always_comb begin
        both_sel  = !ce_prog_n && !ce_data_n;
        prog_only = !ce_prog_n &&  ce_data_n;
        data_only =  ce_prog_n && !ce_data_n;
        rd_req    = !oe_n && we_n;
        wr_allow  = !we_n && we_ok && oe_n && armed && supply_ok;
    end

    // Build the routing result from the qualified access.
    always_comb begin
        route           = '0;
        route.prog_wr   = prog_only && wr_allow;
        route.data_wr   = data_only && wr_allow;
        route.prog_rd   = prog_only && rd_req && !prog_busy;
        route.prog_poll = prog_only && rd_req &&  prog_busy;
        route.data_rd   = data_only && rd_req && !prog_busy && !data_busy;
        route.data_poll = data_only && rd_req && !prog_busy &&  data_busy;
        route.illegal   = (both_sel && (!we_n || !oe_n))
                        || (data_only && rd_req && prog_busy);
    end
endmodule

// File: rtl/dual_array_guard.sv
// Module: top of the dual-array access arbiter and write guard.
// Filters the write enable, applies the power-up lockout, routes each access
// and keeps a sticky illegal-access flag.
// Assumes: inputs are synchronous to clk; FILT_CYCLES and LOCK_CYCLES are >= 1.
module dual_array_guard
    import dag_pkg::*;
#(
    parameter int unsigned FILT_CYCLES = 2,
    parameter int unsigned LOCK_CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_prog_n,
    input  logic ce_data_n,
    input  logic we_n,
    input  logic oe_n,
    input  logic supply_ok,
    input  logic prog_busy,
    input  logic data_busy,
    output logic prog_rd,
    output logic prog_wr,
    output logic prog_poll,
    output logic data_rd,
    output logic data_wr,
    output logic data_poll,
    output logic access_err
);
    logic   we_ok, armed;
    route_t route;
    logic   err_q;

    // Glitch filter: count consecutive low samples of the write enable.
    dag_run_counter #(.LIMIT(FILT_CYCLES)) u_filt (
        .clk(clk), .rst_n(rst_n), .level(!we_n), .done(we_ok)
    );

    // Power-up lockout: count consecutive good-supply samples.
    dag_run_counter #(.LIMIT(LOCK_CYCLES)) u_lock (
        .clk(clk), .rst_n(rst_n), .level(supply_ok), .done(armed)
    );

    dag_router u_route (
        .ce_prog_n(ce_prog_n), .ce_data_n(ce_data_n), .we_n(we_n), .oe_n(oe_n),
        .supply_ok(supply_ok), .we_ok(we_ok), .armed(armed),
        .prog_busy(prog_busy), .data_busy(data_busy), .route(route)
    );

    // Sticky error: set by any illegal access, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (route.illegal)
            err_q <= 1'b1;
    end

    // Drive the outputs from the routing result.
    assign prog_rd    = route.prog_rd;
    assign prog_wr    = route.prog_wr;
    assign prog_poll  = route.prog_poll;
    assign data_rd    = route.data_rd;
    assign data_wr    = route.data_wr;
    assign data_poll  = route.data_poll;
    assign access_err = err_q;
endmodule

// File: rtl/dag_checker.sv
// Module: assertion checker for dual_array_guard, attached with bind.
// Keeps its own run counters for the write-enable and supply windows.
module dag_checker #(
    parameter int unsigned FILT_CYCLES = 2,
    parameter int unsigned LOCK_CYCLES = 1000000
) (
    input logic clk,
    input logic rst_n,
    input logic ce_prog_n,
    input logic ce_data_n,
    input logic we_n,
    input logic oe_n,
    input logic supply_ok,
    input logic prog_busy,
    input logic data_busy,
    input logic prog_rd,
    input logic prog_wr,
    input logic prog_poll,
    input logic data_rd,
    input logic data_wr,
    input logic data_poll,
    input logic access_err
);
    logic [31:0] we_run, sup_run;
    logic        any_wr;

    // Count the write-enable low run and the supply-good run independently.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_run  <= '0;
            sup_run <= '0;
        end else begin
            we_run  <= we_n ? 32'd0 : ((we_run == 32'hFFFF_FFFF) ? we_run : we_run + 1);
            sup_run <= !supply_ok ? 32'd0 : ((sup_run == 32'hFFFF_FFFF) ? sup_run : sup_run + 1);
        end
    end

    assign any_wr = prog_wr || data_wr;

    p_glitch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        any_wr |-> (we_run >= FILT_CYCLES));
    p_lockout_r2: assert property (@(posedge clk) disable iff (!rst_n)
        any_wr |-> (sup_run >= LOCK_CYCLES));
    p_inhibit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        any_wr |-> (oe_n && !we_n));
    p_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_wr |-> !ce_prog_n) and (data_wr |-> !ce_data_n));
    p_dual_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_prog_n && !ce_data_n) |->
        !(prog_rd || prog_wr || prog_poll || data_rd || data_wr || data_poll));
    p_refuse_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        prog_busy |-> (!data_rd && !data_poll));
    p_poll_r7: assert property (@(posedge clk) disable iff (!rst_n)
        prog_busy |-> !prog_rd);
    p_supply_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |-> !any_wr);
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        access_err |=> access_err);
    p_one_hot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_rd, prog_wr, prog_poll, data_rd, data_wr, data_poll}));
endmodule

bind dual_array_guard dag_checker #(
    .FILT_CYCLES(FILT_CYCLES),
    .LOCK_CYCLES(LOCK_CYCLES)
) chk_i (.*);

// File: tb/dual_array_guard_tb_top.sv
// Bench: a behavioural reference model, compared with the design on every clock.
module dual_array_guard_tb_top;
    localparam int F = 3;
    localparam int L = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_prog_n = 1'b1, ce_data_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic supply_ok = 1'b0, prog_busy = 1'b0, data_busy = 1'b0;
    logic prog_rd, prog_wr, prog_poll, data_rd, data_wr, data_poll, access_err;

    int errors = 0;
    int checks = 0;
    int m_we_run = 0, m_sup_run = 0;
    bit m_err = 0;
    bit s_prog_rd, s_prog_wr, s_prog_poll, s_data_rd, s_data_wr, s_data_poll, s_err;

    always #5 clk = ~clk;

    dual_array_guard #(.FILT_CYCLES(F), .LOCK_CYCLES(L)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_prog_n(ce_prog_n), .ce_data_n(ce_data_n),
        .we_n(we_n), .oe_n(oe_n), .supply_ok(supply_ok), .prog_busy(prog_busy),
        .data_busy(data_busy), .prog_rd(prog_rd), .prog_wr(prog_wr),
        .prog_poll(prog_poll), .data_rd(data_rd), .data_wr(data_wr),
        .data_poll(data_poll), .access_err(access_err)
    );

    task automatic chk(input bit act, input bit exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, compare before the rising edge, update the model.
    task automatic cyc(input bit cp, input bit cd, input bit w, input bit o,
                       input bit s, input bit pb, input bit db);
        bit rd, wok, psel, dsel, illegal;
        @(negedge clk);
        ce_prog_n = cp; ce_data_n = cd; we_n = w; oe_n = o;
        supply_ok = s; prog_busy = pb; data_busy = db;
        #3;
        psel = !cp && cd;
        dsel = cp && !cd;
        rd   = !o && w;
        wok  = !w && o && s && (m_we_run >= F) && (m_sup_run >= L);
        illegal = (!cp && !cd && (!w || !o)) || (dsel && rd && pb);
        s_prog_rd = prog_rd; s_prog_wr = prog_wr; s_prog_poll = prog_poll;
        s_data_rd = data_rd; s_data_wr = data_wr; s_data_poll = data_poll;
        s_err = access_err;
        if (rst_n) begin
            chk(prog_wr,   psel && wok,               "R1 prog_wr");
            chk(data_wr,   dsel && wok,               "R11 data_wr");
            chk(prog_rd,   psel && rd && !pb,         "R5 prog_rd");
            chk(prog_poll, psel && rd && pb,          "R7 prog_poll");
            chk(data_rd,   dsel && rd && !pb && !db,  "R6 data_rd");
            chk(data_poll, dsel && rd && !pb && db,   "R7 data_poll");
            chk(access_err, m_err,                    "R9 access_err");
        end
        @(posedge clk);
        #1;
        if (!rst_n) begin
            m_we_run = 0; m_sup_run = 0; m_err = 0;
        end else begin
            m_we_run  = w ? 0 : m_we_run + 1;
            m_sup_run = s ? m_sup_run + 1 : 0;
            if (illegal) m_err = 1;
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (3) cyc(1, 1, 1, 1, 0, 0, 0);
        rst_n = 1'b1;
        cyc(1, 1, 1, 1, 0, 0, 0);
        chk(s_err, 0, "R10 err after reset");

        // R2: write attempt during lockout; the filter completes first
        for (int i = 0; i < L - 1; i++) begin
            cyc(0, 1, 0, 1, 1, 0, 0);
            chk(s_prog_wr, 0, "R2 lockout blocks write");
        end
        // Lockout ends while the write is held: the strobe appears once both counts complete
        cyc(0, 1, 0, 1, 1, 0, 0);
        cyc(0, 1, 0, 1, 1, 0, 0);
        chk(s_prog_wr, 1, "R2 write after lockout");
        cyc(1, 1, 1, 1, 1, 0, 0);

        // R1: short pulse rejected, long pulse accepted
        for (int i = 0; i < F; i++) begin
            cyc(0, 1, 0, 1, 1, 0, 0);
            chk(s_prog_wr, 0, "R1 short low pulse");
        end
        cyc(1, 1, 1, 1, 1, 0, 0);
        for (int i = 0; i <= F; i++) cyc(0, 1, 0, 1, 1, 0, 0);
        chk(s_prog_wr, 1, "R1 filtered write");

        // R3: output enable low inhibits the write
        cyc(0, 1, 0, 0, 1, 0, 0);
        chk(s_prog_wr, 0, "R3 oe low inhibits");
        cyc(1, 1, 0, 1, 1, 0, 0);
        chk(s_prog_wr, 0, "R3 ce high inhibits");
        cyc(1, 1, 1, 1, 1, 0, 0);

        // R11: data-array write
        for (int i = 0; i <= F; i++) cyc(1, 0, 0, 1, 1, 0, 0);
        chk(s_data_wr, 1, "R11 data write");
        // R8: supply drop in the same cycle as a qualified write
        cyc(1, 0, 0, 1, 0, 0, 0);
        chk(s_data_wr, 0, "R8 supply drop");
        cyc(1, 1, 1, 1, 1, 0, 0);
        repeat (L + 1) cyc(1, 1, 1, 1, 1, 0, 0);

        // R5: program read while the data array writes
        cyc(0, 1, 1, 0, 1, 0, 1);
        chk(s_prog_rd, 1, "R5 prog read during data write");
        // R7: polling reads
        cyc(0, 1, 1, 0, 1, 1, 0);
        chk(s_prog_poll, 1, "R7 prog poll");
        cyc(1, 0, 1, 0, 1, 0, 1);
        chk(s_data_poll, 1, "R7 data poll");
        chk(s_err, 0, "R9 no error yet");

        // R6: data read during program write is refused and flagged
        cyc(1, 0, 1, 0, 1, 1, 0);
        chk(s_data_rd, 0, "R6 data read refused");
        cyc(1, 1, 1, 1, 1, 0, 0);
        chk(s_err, 1, "R6 error raised");
        repeat (3) cyc(1, 1, 1, 1, 1, 0, 0);
        chk(s_err, 1, "R9 error sticky");

        // R10: reset clears the flag and the lockout
        rst_n = 1'b0;
        cyc(1, 1, 1, 1, 1, 0, 0);
        rst_n = 1'b1;
        cyc(1, 1, 1, 1, 1, 0, 0);
        chk(s_err, 0, "R10 err cleared");
        for (int i = 0; i <= F; i++) cyc(0, 1, 0, 1, 1, 0, 0);
        chk(s_prog_wr, 0, "R10 lockout restarts");
        cyc(1, 1, 1, 1, 1, 0, 0);

        // R4: both chip enables low
        cyc(0, 0, 1, 0, 1, 0, 0);
        chk(s_prog_rd | s_data_rd, 0, "R4 dual select ignored");
        cyc(1, 1, 1, 1, 1, 0, 0);
        chk(s_err, 1, "R4 dual select flagged");
        cyc(1, 1, 1, 1, 1, 0, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule